// File: doc/BRIEF.md
# Bus Cycle Termination Resolver

This block sits inside a bus master's cycle controller and decides how a bus cycle ends. The master gives two strobes: one on the clock where the even bus state N begins, and one two bus states later, at N+2. On each strobe the block reads three active-low response lines from the slave: acknowledge, bus error and halt. From the pair of readings it picks one of four outcomes. The cycle can complete normally, complete and then halt, end with a bus-error exception, or end and be retried.

The outcome appears as a one-cycle, one-hot pulse. When the outcome is a halt or a retry, a stall level rises with the pulse and stays high while halt is held. The master re-runs the same cycle, or carries on, once the stall drops. Any pair of readings outside the legal combinations is reported as a bus error.

Top module: `bus_term_resolver`

## Requirements
- R1: While synchronous active-high reset is high, and on the first clock after it is released, `result` is 0 and `stall` is low.
- R2: If acknowledge is asserted at N and bus error and halt are both negated at N, the result is done (`result` bit 3). This holds when bus error is negated at N+2, whatever halt does at N+2. The pulse appears in the clock after the N+2 strobe and lasts one cycle.
- R3: If acknowledge and halt are both asserted at N, bus error is negated at N, and bus error is negated at N+2, the result is halted (`result` bit 2). `stall` rises with the pulse.
- R4: If bus error is asserted at N and halt is negated at N, the result is bus error (`result` bit 1). Acknowledge at N and all readings at N+2 have no effect on this.
- R5: If acknowledge alone is asserted at N and bus error is asserted at N+2 while halt is negated at N+2, the result is bus error.
- R6: If bus error and halt are both asserted at N, the result is retry (`result` bit 0). `stall` rises with the pulse.
- R7: If acknowledge alone is asserted at N and bus error and halt are both asserted at N+2, the result is retry. `stall` rises with the pulse.
- R8: Any pair of readings not covered by R2 to R7 gives bus error. This includes neither acknowledge nor bus error asserted at N. It also includes acknowledge and halt asserted at N followed by bus error asserted at N+2.
- R9: Once high, `stall` stays high on every clock where halt is sampled asserted. It goes low in the clock after halt is first sampled negated.
- R10: While `stall` is high, both strobes are ignored and no result is produced. An N+2 strobe that has no earlier N strobe produces no result.
- R11: `result` has at most one bit set. The bit order is {done, halted, bus error, retry} from bit 3 down to bit 0. No two results occur in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_first | input | 1 | Strobe marking the rising edge of even state N |
| sample_second | input | 1 | Strobe marking the rising edge of state N+2 |
| ack_n | input | 1 | Data acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |
| halt_n | input | 1 | Halt, active low |
| result | output | 4 | One-hot outcome pulse {done, halted, bus_error, retry} |
| stall | output | 1 | High while a halt or retry waits for halt to be negated |

## Verification
The bench targets the late-response window. An acknowledge at N followed by bus error at N+2 must become an exception, and the same with halt must become a retry. A resolver that looked only at state N would report done in both cases. The bench also checks that halt arriving alone at N+2 after a clean acknowledge still counts as done, so a design that treated it as a halt would raise a stall it never clears. It pulses strobes during a stall and sends an N+2 strobe with no earlier N strobe, to catch a design that produces phantom results. It checks that the stall drops exactly one clock after halt is released, to catch an off-by-one in the release path.

// File: rtl/bctr_pkg.sv
package bctr_pkg;

  localparam int RES_W = 4;

  localparam logic [RES_W-1:0] RES_NONE   = 4'b0000;
  localparam logic [RES_W-1:0] RES_DONE   = 4'b1000;
  localparam logic [RES_W-1:0] RES_HALTED = 4'b0100;
  localparam logic [RES_W-1:0] RES_BERR   = 4'b0010;
  localparam logic [RES_W-1:0] RES_RETRY  = 4'b0001;

  // response lines converted to active-high form
  typedef struct packed {
    logic ack;
    logic berr;
    logic halt;
  } resp_t;

  function automatic resp_t from_pins(input logic ack_n, input logic berr_n,
                                      input logic halt_n);
    resp_t r;
    r.ack  = ~ack_n;
    r.berr = ~berr_n;
    r.halt = ~halt_n;
    return r;
  endfunction

  // outcome from the reading at state N (a) and state N+2 (b)
  function automatic logic [RES_W-1:0] resolve(input resp_t a, input resp_t b);
    if (a.berr)  return a.halt ? RES_RETRY : RES_BERR;
    if (!a.ack)  return RES_BERR;
    if (a.halt)  return b.berr ? RES_BERR : RES_HALTED;
    if (b.berr)  return b.halt ? RES_RETRY : RES_BERR;
    return RES_DONE;
  endfunction

  function automatic logic wants_stall(input logic [RES_W-1:0] res);
    return (res == RES_HALTED) || (res == RES_RETRY);
  endfunction

endpackage

// File: rtl/bctr_capture.sv
module bctr_capture
  import bctr_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  take,
  input  logic  drop,
  input  resp_t live,
  output resp_t held,
  output logic  held_valid
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held       <= '0;
      held_valid <= 1'b0;
    end else if (drop) begin
      held_valid <= 1'b0;
    end else if (take) begin
      held       <= live;
      held_valid <= 1'b1;
    end
  end

  // R10: a first-state reading only becomes valid through a take
  assert_capture_needs_take_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(held_valid) |-> $past(take));

endmodule

// File: rtl/bctr_stall.sv
module bctr_stall (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic halt_live,
  output logic stall_q
);

  logic release_evt;
  assign release_evt = stall_q && !halt_live;

  always_ff @(posedge clk) begin
    if (rst)              stall_q <= 1'b0;
    else if (release_evt) stall_q <= 1'b0;
    else if (set_req)     stall_q <= 1'b1;
  end

  // R9: stall only rises on a halt or retry decision
  assert_stall_rise_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(stall_q) |-> $past(set_req));

  // R9: stall holds while halt is sampled asserted
  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (stall_q && halt_live) |=> stall_q);

  // R9: stall drops one clock after halt is seen negated
  assert_stall_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (stall_q && !halt_live) |=> !stall_q);

endmodule

// File: rtl/bctr_decide.sv
module bctr_decide
  import bctr_pkg::*;
(
  input  resp_t             first_rd,
  input  resp_t             second_rd,
  output logic [RES_W-1:0]  outcome,
  output logic              needs_stall
);

  always_comb begin
    outcome     = resolve(first_rd, second_rd);
    needs_stall = wants_stall(outcome);
  end

  // R11: the decision itself is always exactly one outcome
  always_comb begin
    assert_decide_onehot_R11: assert ($onehot(outcome) || $isunknown(outcome));
  end

endmodule

// File: rtl/bus_term_resolver.sv
module bus_term_resolver
  import bctr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             sample_first,
  input  logic             sample_second,
  input  logic             ack_n,
  input  logic             berr_n,
  input  logic             halt_n,
  output logic [RES_W-1:0] result,
  output logic             stall
);

  resp_t            live_rd;
  resp_t            first_rd;
  logic             first_valid;
  logic             decide_evt;
  logic             capture_evt;
  logic [RES_W-1:0] outcome;
  logic             needs_stall;
  logic             stall_q;
  logic [RES_W-1:0] result_q;

  assign live_rd     = from_pins(ack_n, berr_n, halt_n);
  assign decide_evt  = sample_second && first_valid && !stall_q;
  assign capture_evt = sample_first && !stall_q && !decide_evt;

  bctr_capture u_capture (
    .clk        (clk),
    .rst        (rst),
    .take       (capture_evt),
    .drop       (decide_evt),
    .live       (live_rd),
    .held       (first_rd),
    .held_valid (first_valid)
  );

  bctr_decide u_decide (
    .first_rd    (first_rd),
    .second_rd   (live_rd),
    .outcome     (outcome),
    .needs_stall (needs_stall)
  );

  bctr_stall u_stall (
    .clk       (clk),
    .rst       (rst),
    .set_req   (decide_evt && needs_stall),
    .halt_live (live_rd.halt),
    .stall_q   (stall_q)
  );

  always_ff @(posedge clk) begin
    if (rst)             result_q <= RES_NONE;
    else if (decide_evt) result_q <= outcome;
    else                 result_q <= RES_NONE;
  end

  assign result = result_q;
  assign stall  = stall_q;

  // R11: at most one outcome bit on the port
  assert_result_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0(result));

  // R11: no back-to-back results
  assert_single_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    (result != RES_NONE) |=> (result == RES_NONE));

  // R10: a result needs a second strobe outside a stall
  assert_result_after_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    (result != RES_NONE) |-> ($past(sample_second) && !$past(stall)));

  // R6: halted and retry results come with the stall raised
  assert_stall_with_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (result[0] || result[2]) |-> stall);

  // R2: done and bus error never raise the stall
  assert_no_stall_on_done_R2: assert property (@(posedge clk) disable iff (rst)
    ((result[3] || result[1]) && !$past(stall)) |-> !stall);

endmodule

// File: tb/bus_term_resolver_test.sv
module bus_term_resolver_test;

  logic       clk = 1'b0;
  logic       rst;
  logic       sample_first, sample_second;
  logic       ack_n, berr_n, halt_n;
  logic [3:0] result;
  logic       stall;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;  // 125 MHz

  bus_term_resolver uut (
    .clk(clk), .rst(rst), .sample_first(sample_first), .sample_second(sample_second),
    .ack_n(ack_n), .berr_n(berr_n), .halt_n(halt_n), .result(result), .stall(stall)
  );

  // behavioural reference model
  bit       m_have, m_ack, m_berr, m_halt, m_stall;
  bit [3:0] m_res;

  function automatic bit [3:0] expect_of(bit aa, bit ab, bit ah, bit ba, bit bb, bit bh);
    bit [3:0] r;
    ba = ba;
    case ({aa, ab, ah})
      3'b010, 3'b110: r = 4'd2;            // error at N, no halt
      3'b011, 3'b111: r = 4'd1;            // error plus halt at N
      3'b100:         r = bb ? (bh ? 4'd1 : 4'd2) : 4'd8;
      3'b101:         r = bb ? 4'd2 : 4'd4;
      default:        r = 4'd2;            // nothing sensible at N
    endcase
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_have = 0; m_stall = 0; m_res = 0;
    end else begin
      m_res = 0;
      if (m_stall) begin
        if (halt_n) m_stall = 0;
      end else if (sample_second && m_have) begin
        m_res  = expect_of(m_ack, m_berr, m_halt, !ack_n, !berr_n, !halt_n);
        m_have = 0;
        if (m_res == 4'd4 || m_res == 4'd1) m_stall = 1;
      end else if (sample_first) begin
        m_have = 1; m_ack = !ack_n; m_berr = !berr_n; m_halt = !halt_n;
      end
    end
  end

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {result,stall}=%b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) check(cur_req, {result, stall}, {m_res, m_stall});
  end

  // a and b: {ack, berr, halt} active high; exp: expected result vector
  task automatic run_pair(string tag, bit [2:0] a, bit [2:0] b, logic [3:0] exp);
    cur_req = tag;
    @(negedge clk);
    sample_first = 1; ack_n = !a[2]; berr_n = !a[1]; halt_n = !a[0];
    @(negedge clk);
    sample_first = 0;
    @(negedge clk);
    sample_second = 1; ack_n = !b[2]; berr_n = !b[1]; halt_n = !b[0];
    @(negedge clk);
    sample_second = 0; ack_n = 1; berr_n = 1;
    check(tag, {1'b0, result}, {1'b0, exp});
  endtask

  task automatic release_halt(string tag, int hold);
    cur_req = tag;
    repeat (hold) begin
      @(negedge clk);
      check(tag, {4'b0, stall}, 5'b00001);
    end
    halt_n = 1;
    @(negedge clk);
    check(tag, {4'b0, stall}, 5'b00000);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; sample_first = 0; sample_second = 0; ack_n = 1; berr_n = 1; halt_n = 1;
    repeat (3) @(negedge clk);
    check("R1", {result, stall}, 5'b0);
    rst = 0;
    @(negedge clk);
    check("R1", {result, stall}, 5'b0);

    run_pair("R2", 3'b100, 3'b100, 4'b1000);
    run_pair("R2", 3'b100, 3'b101, 4'b1000);   // halt alone at N+2 is ignored
    halt_n = 1; @(negedge clk);
    check("R2", {result, stall}, 5'b0);

    run_pair("R3", 3'b101, 3'b101, 4'b0100);
    release_halt("R9", 4);

    run_pair("R4", 3'b010, 3'b000, 4'b0010);
    run_pair("R4", 3'b110, 3'b111, 4'b0010);
    halt_n = 1; @(negedge clk);

    run_pair("R5", 3'b100, 3'b110, 4'b0010);

    run_pair("R6", 3'b011, 3'b011, 4'b0001);
    // strobes during the stall are ignored
    cur_req = "R10";
    @(negedge clk); sample_first = 1; ack_n = 0;
    @(negedge clk); sample_first = 0; sample_second = 1;
    @(negedge clk); sample_second = 0; ack_n = 1;
    check("R10", {result, stall}, 5'b00001);
    release_halt("R9", 2);

    run_pair("R7", 3'b100, 3'b111, 4'b0001);
    release_halt("R9", 1);

    run_pair("R8", 3'b000, 3'b100, 4'b0010);
    run_pair("R8", 3'b001, 3'b000, 4'b0010);
    halt_n = 1;
    run_pair("R8", 3'b101, 3'b111, 4'b0010);
    halt_n = 1; @(negedge clk);

    // second strobe with no first strobe
    cur_req = "R10";
    @(negedge clk); sample_second = 1; ack_n = 0;
    @(negedge clk); sample_second = 0; ack_n = 1;
    check("R10", {result, stall}, 5'b0);

    cur_req = "R11";
    run_pair("R11", 3'b100, 3'b000, 4'b1000);
    @(negedge clk);
    check("R11", {result, stall}, 5'b0);

    repeat (3) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule